// File: doc/BRIEF.md
# Two-Channel DMA Local Bus Arbiter

This block decides who drives the local bus when two DMA channels and a direct-access path (a PCI-side master reaching local memory, or a local master reaching PCI) all want it. The direct-access path always wins. Between the two DMA channels the arbiter applies either a fixed preference or a rotating one. Arbitration is non-preemptive: a channel that holds the bus keeps it until its tenure ends. A tenure ends on a termination event, on a latency limit, on an external bus request or on a direct-access request.

Each channel presents a request level, a demand-mode flag, and single-cycle pulses for end-of-transfer, FIFO stop (FIFO empty or full, depending on direction) and completion. For a demand-mode channel, the request level is its demand request, so dropping it ends the tenure. The arbiter also sees an external bus request, a local latency limit with an enable, and a 2-bit priority setting. It drives registered grants and a one-cycle release strobe. Every change of owner passes through one idle cycle, and the strobe is high in that cycle.

Top module: `dma_lbus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all grants and the release strobe are low.
- R2: At most one of dsGnt, dmaGnt[0] and dmaGnt[1] is high. A non-zero grant value never changes straight into a different non-zero value; it returns to zero first.
- R3: When an owner's tenure ends at a clock edge, in the following cycle all grants are low and releaseStb is high for exactly that one cycle. A new grant can appear at the earliest in the cycle after that.
- R4: In an idle cycle, dsReq high grants dsGnt in the next cycle, even if channels are requesting. dsReq high while a DMA channel owns the bus ends that channel's tenure. dsGnt is held until dsReq falls.
- R5: extBreq high ends a DMA tenure, and no DMA grant is issued while it is high.
- R6: The owning channel's tenure ends when its chEot, chStop or chDone pulse is high, or when its chReq bit is low. The owning channel's tenure also ends when its chReq bit falls, which is how a demand channel drops its demand request.
- R7: When both channels request, a channel with chDemand=0 (block or scatter/gather) is chosen over a channel with chDemand=1, whatever the priority setting is.
- R8: When both channels request in the same mode class, prioSel=01 picks channel 0 and prioSel=10 picks channel 1. A channel that holds the bus is never preempted by the favoured channel.
- R9: With prioSel=00 or 11 (rotating), the rotation pointer selects channel 0 after reset, and it is set back to channel 0 whenever both chReq bits are low. After each DMA tenure ends, the pointer moves to the other channel. A channel that is the only requester is granted again.
- R10: With latEn=1, a DMA owner holds its grant for exactly latLimit+1 cycles before release, unless another event ends the tenure first. The count restarts with every grant. With latEn=0, the limit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dsReq | input | 1 | Direct-access path request |
| extBreq | input | 1 | External master bus request |
| chReq | input | 2 | Per-channel request (demand request for demand channels) |
| chDemand | input | 2 | Per-channel mode: 1 = demand, 0 = block or scatter/gather |
| chEot | input | 2 | Per-channel end-of-transfer pulse |
| chStop | input | 2 | Per-channel FIFO empty/full stop pulse |
| chDone | input | 2 | Per-channel completion pulse |
| prioSel | input | 2 | 00 rotating, 01 channel 0 first, 10 channel 1 first, 11 rotating |
| latEn | input | 1 | Enable for the local latency limit |
| latLimit | input | LAT_W | Latency limit in cycles minus one |
| dmaGnt | output | 2 | One-hot DMA channel grant |
| dsGnt | output | 1 | Direct-access path grant |
| releaseStb | output | 1 | One-cycle strobe in the idle cycle after a tenure ends |

## Verification
Every result is one register stage behind the inputs that cause it. An end of tenure seen at an edge shows as the strobe with zero grants in the next cycle, and a new grant follows one cycle later. The bench drives each stimulus row at a falling edge and compares the outputs at the next falling edge, so exactly one rising edge lies between cause and observation. Latency checks count falling-edge samples: there should be latLimit+1 granted samples, then one strobe sample, then the regrant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CH_N = 2;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CH0  = 2'd1,
    OWN_CH1  = 2'd2,
    OWN_DS   = 2'd3
  } owner_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic rotToOther;
    logic rotFrom;
    logic rotReset;
  } dp_ctl_t;
endpackage

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctl_t          ctl,
  input  logic             latEn,
  input  logic [LAT_W-1:0] latLimit,
  output logic             latExpired,
  output logic             rrPtr
);
  logic [LAT_W-1:0] latCnt;

  // tenure length counter, restarted while the bus is idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latCnt <= '0;
    else if (ctl.cntClear) latCnt <= '0;
    else if (ctl.cntInc)   latCnt <= latCnt + 1'b1;
  end

  // rotation pointer: channel favoured next under rotating priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rrPtr <= 1'b0;
    else if (ctl.rotReset)   rrPtr <= 1'b0;
    else if (ctl.rotToOther) rrPtr <= ~ctl.rotFrom;
  end

  assign latExpired = latEn && (latCnt == latLimit);
endmodule

// File: rtl/dma_arb_ctl.sv
module dma_arb_ctl
  import dma_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            dsReq,
  input  logic            extBreq,
  input  logic [CH_N-1:0] chReq,
  input  logic [CH_N-1:0] chDemand,
  input  logic [CH_N-1:0] chEot,
  input  logic [CH_N-1:0] chStop,
  input  logic [CH_N-1:0] chDone,
  input  logic [1:0]      prioSel,
  input  logic            latExpired,
  input  logic            rrPtr,
  output dp_ctl_t         ctl,
  output logic [CH_N-1:0] dmaGnt,
  output logic            dsGnt,
  output logic            releaseStb
);
  owner_e owner, ownerNext;
  logic   relReg;
  logic   ownIdx, ownerIsDma, dmaEnd;
  logic   pickValid, pickIdx;

  assign ownerIsDma = (owner == OWN_CH0) || (owner == OWN_CH1);
  assign ownIdx     = (owner == OWN_CH1);

  assign dmaEnd = dsReq || extBreq || latExpired ||
                  chEot[ownIdx] || chStop[ownIdx] || chDone[ownIdx] ||
                  !chReq[ownIdx];

  // channel selection for an idle cycle
  always_comb begin
    pickValid = |chReq;
    pickIdx   = 1'b0;
    if (chReq == 2'b11) begin
      if (chDemand[0] != chDemand[1]) begin
        pickIdx = chDemand[0];
      end else begin
        unique case (prioSel)
          2'b01:   pickIdx = 1'b0;
          2'b10:   pickIdx = 1'b1;
          default: pickIdx = rrPtr;
        endcase
      end
    end else begin
      pickIdx = chReq[1] && !chReq[0];
    end
  end

  always_comb begin
    ownerNext = owner;
    unique case (owner)
      OWN_NONE: begin
        if (dsReq)                       ownerNext = OWN_DS;
        else if (!extBreq && pickValid)  ownerNext = pickIdx ? OWN_CH1 : OWN_CH0;
      end
      OWN_DS:  if (!dsReq) ownerNext = OWN_NONE;
      default: if (dmaEnd) ownerNext = OWN_NONE;
    endcase
  end

  always_comb begin
    ctl            = '0;
    ctl.cntClear   = (owner == OWN_NONE);
    ctl.cntInc     = ownerIsDma && !dmaEnd;
    ctl.rotToOther = ownerIsDma && dmaEnd;
    ctl.rotFrom    = ownIdx;
    ctl.rotReset   = (chReq == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner  <= OWN_NONE;
      relReg <= 1'b0;
    end else begin
      owner  <= ownerNext;
      relReg <= (owner != OWN_NONE) && (ownerNext == OWN_NONE);
    end
  end

  assign dmaGnt     = {owner == OWN_CH1, owner == OWN_CH0};
  assign dsGnt      = (owner == OWN_DS);
  assign releaseStb = relReg;
endmodule

// File: rtl/dma_lbus_arbiter.sv
module dma_lbus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dsReq,
  input  logic             extBreq,
  input  logic [1:0]       chReq,
  input  logic [1:0]       chDemand,
  input  logic [1:0]       chEot,
  input  logic [1:0]       chStop,
  input  logic [1:0]       chDone,
  input  logic [1:0]       prioSel,
  input  logic             latEn,
  input  logic [LAT_W-1:0] latLimit,
  output logic [1:0]       dmaGnt,
  output logic             dsGnt,
  output logic             releaseStb
);
  dp_ctl_t ctl;
  logic    latExpired, rrPtr;

  dma_arb_ctl u_ctl (
    .clk(clk), .rstN(rstN), .dsReq(dsReq), .extBreq(extBreq),
    .chReq(chReq), .chDemand(chDemand), .chEot(chEot), .chStop(chStop),
    .chDone(chDone), .prioSel(prioSel), .latExpired(latExpired),
    .rrPtr(rrPtr), .ctl(ctl), .dmaGnt(dmaGnt), .dsGnt(dsGnt),
    .releaseStb(releaseStb)
  );

  dma_arb_dp #(.LAT_W(LAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .latEn(latEn),
    .latLimit(latLimit), .latExpired(latExpired), .rrPtr(rrPtr)
  );
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int LAT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             dsReq,
  input logic             extBreq,
  input logic [1:0]       chReq,
  input logic [LAT_W-1:0] latLimit,
  input logic [1:0]       dmaGnt,
  input logic             dsGnt,
  input logic             releaseStb
);
  logic [2:0] gntAll;
  assign gntAll = {dsGnt, dmaGnt};

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntAll));

  assert_no_direct_switch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|gntAll) |=> (gntAll == $past(gntAll)) || (gntAll == '0));

  assert_strobe_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    releaseStb |-> (gntAll == '0));

  assert_strobe_on_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(|gntAll) && gntAll == '0) |-> releaseStb);

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    releaseStb |=> !releaseStb);

  assert_ds_wins_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (gntAll == '0 && dsReq) |=> dsGnt);

  assert_ds_preempts_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((|dmaGnt) && dsReq) |=> releaseStb);

  assert_ext_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (gntAll == '0 && extBreq) |=> (dmaGnt == '0));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (gntAll == '0 && !releaseStb));
endmodule

bind dma_lbus_arbiter dma_arb_checker #(.LAT_W(LAT_W)) chk (.*);

// File: tb/tb_dma_lbus_arbiter.sv
module tb_dma_lbus_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dsReq = 0, extBreq = 0, latEn = 0;
  logic [1:0] chReq = 0, chDemand = 0, chEot = 0, chStop = 0, chDone = 0, prioSel = 0;
  logic [7:0] latLimit = 0;
  logic [1:0] dmaGnt;
  logic       dsGnt, releaseStb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_lbus_arbiter dut (.*);

  typedef struct packed {
    logic       ds, ext;
    logic [1:0] req, dem, eot, stop, done, prio;
    logic [1:0] eG;
    logic       eD, eR;
    logic [3:0] tag;
  } vec_t;

  localparam int N = 35;
  localparam vec_t VEC [N] = '{
    // ds ext req   dem   eot   stop  done  prio   eG   eD eR  tag
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b01,0,0, 4'd9}, // R9 fresh start: ch0
    '{0,0,2'b11,2'b00,2'b01,2'b00,2'b00,2'b00, 2'b00,0,1, 4'd6}, // R6 ch0 EOT ends tenure
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b10,0,0, 4'd9}, // R9 rotate to ch1
    '{0,1,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,0,1, 4'd5}, // R5 ext request ends tenure
    '{0,1,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,0,0, 4'd5}, // R5 ext blocks grant
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b01,0,0, 4'd9}, // R9 back to ch0
    '{1,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,0,1, 4'd4}, // R4 direct access preempts
    '{1,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,1,0, 4'd4}, // R4 direct access granted
    '{1,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,1,0, 4'd4}, // R4 held
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,0,1, 4'd3}, // R3 strobe on ds release
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b10,0,0, 4'd9}, // R9 pointer kept at ch1
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b10,2'b00, 2'b00,0,1, 4'd6}, // R6 ch1 done
    '{0,0,2'b01,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b01,0,0, 4'd9}, // R9 ch0 alone
    '{0,0,2'b01,2'b00,2'b01,2'b00,2'b00,2'b00, 2'b00,0,1, 4'd6}, // R6 EOT
    '{0,0,2'b01,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b01,0,0, 4'd9}, // R9 sole requester regains
    '{0,0,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,0,1, 4'd6}, // R6 request drop
    '{0,0,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,0,0, 4'd3}, // R3 strobe lasts one cycle
    '{0,0,2'b01,2'b00,2'b00,2'b00,2'b00,2'b10, 2'b01,0,0, 4'd8}, // R8 ch0 alone
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b10, 2'b01,0,0, 4'd8}, // R8 no preemption
    '{0,0,2'b11,2'b00,2'b00,2'b01,2'b00,2'b10, 2'b00,0,1, 4'd6}, // R6 FIFO stop
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b10, 2'b10,0,0, 4'd8}, // R8 ch1 favoured
    '{0,0,2'b11,2'b00,2'b10,2'b00,2'b00,2'b10, 2'b00,0,1, 4'd6}, // R6 EOT
    '{0,0,2'b11,2'b00,2'b00,2'b00,2'b00,2'b10, 2'b10,0,0, 4'd8}, // R8 favoured again
    '{0,0,2'b01,2'b00,2'b00,2'b00,2'b00,2'b10, 2'b00,0,1, 4'd6}, // R6 ch1 request drop
    '{0,0,2'b01,2'b00,2'b00,2'b00,2'b00,2'b10, 2'b01,0,0, 4'd8}, // R8 ch0 after ch1 done
    '{0,0,2'b00,2'b00,2'b00,2'b00,2'b00,2'b10, 2'b00,0,1, 4'd6}, // R6
    '{0,0,2'b11,2'b01,2'b00,2'b00,2'b00,2'b01, 2'b10,0,0, 4'd7}, // R7 block beats demand
    '{0,0,2'b11,2'b01,2'b10,2'b00,2'b00,2'b01, 2'b00,0,1, 4'd6}, // R6
    '{0,0,2'b11,2'b01,2'b00,2'b00,2'b00,2'b01, 2'b10,0,0, 4'd7}, // R7 again
    '{0,0,2'b00,2'b01,2'b00,2'b00,2'b00,2'b01, 2'b00,0,1, 4'd6}, // R6
    '{0,0,2'b11,2'b11,2'b00,2'b00,2'b00,2'b11, 2'b01,0,0, 4'd9}, // R9 reserved rotates, ch0
    '{0,0,2'b11,2'b11,2'b01,2'b00,2'b00,2'b11, 2'b00,0,1, 4'd6}, // R6
    '{0,0,2'b11,2'b11,2'b00,2'b00,2'b00,2'b11, 2'b10,0,0, 4'd9}, // R9 reserved rotates, ch1
    '{0,0,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,0,1, 4'd6}, // R6
    '{0,0,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 2'b00,0,0, 4'd3}  // R3 idle
  };

  task automatic drive(vec_t v);
    dsReq = v.ds; extBreq = v.ext; chReq = v.req; chDemand = v.dem;
    chEot = v.eot; chStop = v.stop; chDone = v.done; prioSel = v.prio;
  endtask

  task automatic expect3(string req, logic [1:0] eG, logic eD, logic eR);
    checks++;
    if (dmaGnt !== eG || dsGnt !== eD || releaseStb !== eR) begin
      errors++;
      $display("FAIL %s: got gnt=%b ds=%b rel=%b, expected gnt=%b ds=%b rel=%b",
               req, dmaGnt, dsGnt, releaseStb, eG, eD, eR);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    expect3("R1", 2'b00, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    expect3("R1", 2'b00, 0, 0);

    // table walk
    for (int i = 0; i < N; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      expect3($sformatf("R%0d row %0d", VEC[i].tag, i), VEC[i].eG, VEC[i].eD, VEC[i].eR);
    end

    // R10 latency limit 3: four granted cycles, strobe, regrant
    latEn = 1; latLimit = 8'd3; chReq = 2'b01; prioSel = 2'b00;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      expect3("R10 hold", 2'b01, 0, 0);
    end
    @(negedge clk);
    expect3("R10 expire", 2'b00, 0, 1);
    @(negedge clk);
    expect3("R10 regrant", 2'b01, 0, 0);
    chReq = 2'b00;
    repeat (3) @(negedge clk);

    // R10 disabled limit has no effect
    latEn = 0; chReq = 2'b01;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      expect3("R10 disabled", 2'b01, 0, 0);
    end
    chReq = 2'b00;
    repeat (3) @(negedge clk);

    // R4 direct access and both channels in the same idle cycle
    dsReq = 1; chReq = 2'b11;
    @(negedge clk);
    expect3("R4 simultaneous", 2'b00, 1, 0);
    dsReq = 0; chReq = 2'b00;
    @(negedge clk);
    expect3("R3 ds release", 2'b00, 0, 1);
    @(negedge clk);

    // R1 reset while a channel owns the bus
    chReq = 2'b10;
    @(negedge clk);
    expect3("R1 pre-reset grant", 2'b10, 0, 0);
    rstN = 0;
    #1;
    expect3("R1 async reset", 2'b00, 0, 0);
    chReq = 2'b00;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    summary();
  end
endmodule